// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block watches the command stream that a memory controller sends to a four-bank double-data-rate SDRAM. It samples chip select, the three active-low command strobes, the bank address and the 13-bit address bus on every rising clock edge. From these it decodes row opens, column reads and writes, precharges, refreshes and mode-register loads. For each bank it keeps an open or closed state and the row that was opened.

For every legal access it reports the bank, the column and whether auto precharge was asked for. For every mode-register load it reports which register was written. Commands that break the bank protocol are flagged and have no other effect. Auto precharge is modelled as a countdown that depends on the burst length held in the main mode register, so the tracker closes a bank at the same point the memory would.

A monitor or a controller-side scoreboard uses it to follow which rows are open and to catch protocol slips in simulation or on silicon.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset all banks are closed, accValid, mrsValid and errIllegal are low, the main mode word is 1 (burst length 2) and the extended mode word is 0.
- R2: With csN high, every combination of rasN/casN/weN is treated as no operation: no output pulses and no bank state changes. With csN low, rasN/casN/weN of 1/1/1 and 1/1/0 are also no operation.
- R3: ACTIVE (rasN/casN/weN = 0/1/1) to a closed bank opens it one clock later and stores addr[12:0] as its row in openRows[b*13 +: 13].
- R4: READ (1/0/1) or WRITE (1/0/0) to an open bank gives, one clock later, a one-cycle accValid with accWrite high only for WRITE, accBank equal to the bank address, accCol equal to addr[8:0] and autoPreReq equal to addr[10].
- R5: PRECHARGE (0/1/0) with addr[10] low closes only the addressed bank; with addr[10] high it closes all four banks. It never raises errIllegal.
- R6: A READ or WRITE with addr[10] high leaves the bank open and closes it exactly BL/2 clocks after the command edge, where BL is the burst length in force.
- R7: MODE REGISTER SET (0/0/0) with all banks closed and bank address 0 or 1 gives a one-cycle mrsValid one clock later with mrsTarget equal to bank address bit 0, and stores addr[12:0] in the main (0) or extended (1) mode word. Main-word bits [2:0] select BL: 1 gives 2, 2 gives 4, 3 gives 8, every other code gives 2.
- R8: errIllegal pulses one clock after: READ or WRITE to a closed bank, ACTIVE to an open bank, REFRESH or MODE REGISTER SET while any bank is open, or MODE REGISTER SET with bank address 2 or 3. Such a command changes no bank state, row or mode word and gives no accValid or mrsValid.
- R9: AUTO REFRESH (0/0/1) with all banks closed raises no output and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 2 | Bank address / mode register select |
| addr | input | 13 | Row, column, auto-precharge bit and op code |
| accValid | output | 1 | One-cycle pulse for a legal READ or WRITE |
| accWrite | output | 1 | High when the reported access is a WRITE |
| accBank | output | 2 | Bank of the last reported access |
| accCol | output | 9 | Column of the last reported access |
| autoPreReq | output | 1 | Auto precharge requested by the reported access |
| mrsValid | output | 1 | One-cycle pulse for a legal mode-register load |
| mrsTarget | output | 1 | 0 = main mode word, 1 = extended mode word |
| errIllegal | output | 1 | One-cycle pulse for a protocol violation |
| bankActive | output | 4 | Open flag per bank |
| openRows | output | 52 | Stored row per bank, 13 bits each, bank 0 lowest |
| mainMode | output | 13 | Main mode word |
| extMode | output | 13 | Extended mode word |

## Verification
The assertions assume the reset is held for at least one clock and that bankAddr and addr are stable around each sampling edge. They do not depend on legal traffic, because illegal commands have a defined result. The stimulus drives every input at the falling edge, returns the bus to a no-operation command after each command, and lets each auto-precharge countdown run to completion before it sends more traffic, so the bench's open-bank model stays exact while the burst length is swept over all eight codes.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  localparam int MAX_BURST = 8;
  localparam int CNT_W     = $clog2(MAX_BURST / 2 + 1);

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS
  } cmd_e;

  // legal-command strobes handed from control to datapath
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic mrs;
    logic err;
  } strobe_t;

  // clocks needed to move a burst of the coded length (two beats per clock)
  function automatic logic [CNT_W-1:0] burstHalf(input logic [2:0] code);
    case (code)
      3'd2:    burstHalf = CNT_W'(2);
      3'd3:    burstHalf = CNT_W'(4);
      default: burstHalf = CNT_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/sbt_ctrl.sv
module sbt_ctrl
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      bankAddr,
  input  logic                 apBit,
  input  logic [NUM_BANKS-1:0] bankActive,
  output strobe_t              strobes
);

  cmd_e cmd;
  logic tgtOpen;
  logic anyOpen;

  always_comb begin
    cmd = CMD_NOP;
    if (!csN) begin
      case ({rasN, casN, weN})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_NOP;
      endcase
    end
  end

  assign tgtOpen = bankActive[bankAddr];
  assign anyOpen = |bankActive;

  always_comb begin
    strobes = '0;
    case (cmd)
      CMD_ACT: begin
        if (tgtOpen) strobes.err = 1'b1;
        else         strobes.act = 1'b1;
      end
      CMD_RD: begin
        if (tgtOpen) strobes.rd  = 1'b1;
        else         strobes.err = 1'b1;
      end
      CMD_WR: begin
        if (tgtOpen) strobes.wr  = 1'b1;
        else         strobes.err = 1'b1;
      end
      CMD_PRE: begin
        strobes.pre    = 1'b1;
        strobes.preAll = apBit;
      end
      CMD_REF: begin
        strobes.err = anyOpen;
      end
      CMD_MRS: begin
        if (anyOpen || (bankAddr > BA_W'(1))) strobes.err = 1'b1;
        else                                  strobes.mrs = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/sbt_datapath.sv
module sbt_datapath
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strobes,
  input  logic [BA_W-1:0]            bankAddr,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       accValid,
  output logic                       accWrite,
  output logic [BA_W-1:0]            accBank,
  output logic [COL_W-1:0]           accCol,
  output logic                       autoPreReq,
  output logic                       mrsValid,
  output logic                       mrsTarget,
  output logic                       errIllegal,
  output logic [NUM_BANKS-1:0]       bankActive,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [ADDR_W-1:0]          mainMode,
  output logic [ADDR_W-1:0]          extMode
);

  logic             rwAny;
  logic             rwAp;
  logic [CNT_W-1:0] loadVal;

  assign rwAny   = strobes.rd | strobes.wr;
  assign rwAp    = rwAny & addr[AP_BIT];
  assign loadVal = burstHalf(mainMode[2:0]);

  // access and mode-load reporting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accValid   <= 1'b0;
      accWrite   <= 1'b0;
      accBank    <= '0;
      accCol     <= '0;
      autoPreReq <= 1'b0;
      mrsValid   <= 1'b0;
      mrsTarget  <= 1'b0;
      errIllegal <= 1'b0;
    end else begin
      accValid   <= rwAny;
      mrsValid   <= strobes.mrs;
      errIllegal <= strobes.err;
      if (rwAny) begin
        accWrite   <= strobes.wr;
        accBank    <= bankAddr;
        accCol     <= addr[COL_W-1:0];
        autoPreReq <= addr[AP_BIT];
      end
      if (strobes.mrs) mrsTarget <= bankAddr[0];
    end
  end

  // mode words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainMode <= ADDR_W'(1);
      extMode  <= '0;
    end else if (strobes.mrs) begin
      if (bankAddr[0]) extMode  <= addr;
      else             mainMode <= addr;
    end
  end

  // per-bank state: open flag, row, auto-precharge countdown
  logic             activeQ [NUM_BANKS];
  logic [ROW_W-1:0] rowQ    [NUM_BANKS];
  logic [CNT_W-1:0] apcCnt  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BA_W-1:0] IDX = BA_W'(b);
    logic hit;
    logic preHit;
    assign hit    = (bankAddr == IDX);
    assign preHit = strobes.pre & (strobes.preAll | hit);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activeQ[b] <= 1'b0;
        rowQ[b]    <= '0;
        apcCnt[b]  <= '0;
      end else if (preHit) begin
        activeQ[b] <= 1'b0;
        apcCnt[b]  <= '0;
      end else if (strobes.act && hit) begin
        activeQ[b] <= 1'b1;
        rowQ[b]    <= addr[ROW_W-1:0];
      end else if (rwAp && hit) begin
        apcCnt[b]  <= loadVal;
      end else if (apcCnt[b] == CNT_W'(1)) begin
        activeQ[b] <= 1'b0;
        apcCnt[b]  <= '0;
      end else if (apcCnt[b] != '0) begin
        apcCnt[b]  <= apcCnt[b] - CNT_W'(1);
      end
    end

    assign bankActive[b]               = activeQ[b];
    assign openRows[b*ROW_W +: ROW_W]  = rowQ[b];

    // R6: a countdown reaching its end closes the bank on the next edge
    p_apc_close_r6: assert property (@(posedge clk) disable iff (!rstN)
      (apcCnt[b] == CNT_W'(1) && !(rwAp && hit)) |=> !bankActive[b]);

    // R6: a countdown only runs on an open bank
    p_apc_open_r6: assert property (@(posedge clk) disable iff (!rstN)
      (apcCnt[b] != '0) |-> bankActive[b]);

    // R3: the stored row of an open bank does not move while it stays open
    p_row_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (bankActive[b] && $past(bankActive[b])) |-> $stable(rowQ[b]));
  end

  // bank state one cycle back, for checking reports against it
  logic [NUM_BANKS-1:0] activeD1;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeD1 <= '0;
    else       activeD1 <= bankActive;
  end

  // R4: an access is only reported for a bank that was open when it was issued
  p_acc_open_r4: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> activeD1[accBank]);

  // R8: at most one kind of report per cycle
  p_one_report_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accValid, mrsValid, errIllegal}));

  // R7: a mode load is only accepted with every bank closed
  p_mrs_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    mrsValid |-> (activeD1 == '0) && (bankActive == '0));

  // R8: a rejected command leaves the mode words alone
  p_err_mode_r8: assert property (@(posedge clk) disable iff (!rstN)
    errIllegal |-> ($stable(mainMode) && $stable(extMode)));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [BA_W-1:0]            bankAddr,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       accValid,
  output logic                       accWrite,
  output logic [BA_W-1:0]            accBank,
  output logic [COL_W-1:0]           accCol,
  output logic                       autoPreReq,
  output logic                       mrsValid,
  output logic                       mrsTarget,
  output logic                       errIllegal,
  output logic [NUM_BANKS-1:0]       bankActive,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [ADDR_W-1:0]          mainMode,
  output logic [ADDR_W-1:0]          extMode
);

  strobe_t strobes;

  sbt_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .bankAddr   (bankAddr),
    .apBit      (addr[AP_BIT]),
    .bankActive (bankActive),
    .strobes    (strobes)
  );

  sbt_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W),
    .ADDR_W    (ADDR_W),
    .AP_BIT    (AP_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .bankAddr   (bankAddr),
    .addr       (addr),
    .accValid   (accValid),
    .accWrite   (accWrite),
    .accBank    (accBank),
    .accCol     (accCol),
    .autoPreReq (autoPreReq),
    .mrsValid   (mrsValid),
    .mrsTarget  (mrsTarget),
    .errIllegal (errIllegal),
    .bankActive (bankActive),
    .openRows   (openRows),
    .mainMode   (mainMode),
    .extMode    (extMode)
  );

endmodule

// File: tb/sdram_bank_tracker_bench.sv
module sdram_bank_tracker_bench;

  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;
  localparam logic [2:0] C_MRS = 3'b000;
  localparam logic [2:0] C_NOP = 3'b111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b0;
  logic        rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0]  bankAddr = '0;
  logic [12:0] addr = '0;
  logic        accValid, accWrite, autoPreReq, mrsValid, mrsTarget, errIllegal;
  logic [1:0]  accBank;
  logic [8:0]  accCol;
  logic [3:0]  bankActive;
  logic [51:0] openRows;
  logic [12:0] mainMode, extMode;

  int checks = 0;
  int fails  = 0;
  logic [3:0]  expActive = '0;
  logic [12:0] expRow [4];

  always #4 clk = ~clk;

  sdram_bank_tracker u_sdram_bank_tracker (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .addr(addr), .accValid(accValid), .accWrite(accWrite),
    .accBank(accBank), .accCol(accCol), .autoPreReq(autoPreReq),
    .mrsValid(mrsValid), .mrsTarget(mrsTarget), .errIllegal(errIllegal),
    .bankActive(bankActive), .openRows(openRows), .mainMode(mainMode),
    .extMode(extMode)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one command for one edge, then return to NOP; returns after that edge
  task automatic issue(input logic cs, input logic [2:0] rcw,
                       input logic [1:0] ba, input logic [12:0] a);
    @(negedge clk);
    csN = cs; {rasN, casN, weN} = rcw; bankAddr = ba; addr = a;
    @(negedge clk);
    csN = 1'b0; {rasN, casN, weN} = C_NOP;
  endtask

  function automatic int blOf(input logic [2:0] code);
    if (code == 3'd1) return 2;
    if (code == 3'd2) return 4;
    if (code == 3'd3) return 8;
    return 2;
  endfunction

  function automatic logic [51:0] expRows();
    logic [51:0] r;
    for (int b = 0; b < 4; b++) r[b*13 +: 13] = expRow[b];
    return r;
  endfunction

  // R6: watch an auto-precharged bank close after exactly bl/2 clocks
  task automatic apTiming(input int b, input int bl, input string tag);
    for (int j = 0; j <= bl / 2; j++) begin
      chk(tag, bankActive[b], (j < bl / 2));
      if (j < bl / 2) @(negedge clk);
    end
    expActive[b] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) expRow[b] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 bankActive", bankActive, 0);
    chk("R1 pulses", {accValid, mrsValid, errIllegal}, 0);
    chk("R1 mainMode", mainMode, 1);
    chk("R1 extMode", extMode, 0);

    // R3 open every bank with its own row
    for (int b = 0; b < 4; b++) begin
      logic [12:0] row = 13'(13'h1A5 ^ (b * 1777));
      issue(1'b0, C_ACT, 2'(b), row);
      expActive[b] = 1'b1; expRow[b] = row;
      chk("R3 bankActive", bankActive, expActive);
      chk("R3 openRows", openRows, expRows());
    end

    // R4 reads and writes on open banks, several columns
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 3; k++) begin
        logic [8:0] col = (k == 0) ? 9'h000 : (k == 1) ? 9'h1FF : 9'(b * 37 + 5);
        for (int w = 0; w < 2; w++) begin
          issue(1'b0, w ? C_WR : C_RD, 2'(b), {4'b0000, col});
          chk("R4 accValid", accValid, 1);
          chk("R4 accWrite", accWrite, w);
          chk("R4 accBank", accBank, b);
          chk("R4 accCol", accCol, col);
          chk("R4 autoPreReq", autoPreReq, 0);
          chk("R4 state kept", bankActive, expActive);
        end
      end
    end

    // R2 chip select high masks every command
    for (int c = 0; c < 8; c++) begin
      issue(1'b1, 3'(c), 2'(c % 4), 13'h1400);
      chk("R2 masked pulses", {accValid, mrsValid, errIllegal}, 0);
      chk("R2 masked state", bankActive, expActive);
      chk("R2 masked rows", openRows, expRows());
    end
    // R2 undecoded combination with chip select low
    issue(1'b0, 3'b110, 2'd1, 13'h0400);
    chk("R2 nop combo", {accValid, mrsValid, errIllegal}, 0);
    chk("R2 nop combo state", bankActive, expActive);

    // R8 ACTIVE to an open bank
    issue(1'b0, C_ACT, 2'd0, 13'h0F0F);
    chk("R8 act open err", errIllegal, 1);
    chk("R8 act open row kept", openRows, expRows());
    // R8 REFRESH and MRS with banks open
    issue(1'b0, C_REF, 2'd0, 13'h0);
    chk("R8 ref open err", errIllegal, 1);
    issue(1'b0, C_MRS, 2'd0, 13'h0003);
    chk("R8 mrs open err", {errIllegal, mrsValid}, 2'b10);
    chk("R8 mrs open mode kept", mainMode, 1);

    // R5 single-bank precharge
    issue(1'b0, C_PRE, 2'd2, 13'h0000);
    expActive[2] = 1'b0;
    chk("R5 single close", bankActive, expActive);
    chk("R5 no err", errIllegal, 0);
    // R8 access to the closed bank
    issue(1'b0, C_RD, 2'd2, 13'h0011);
    chk("R8 rd closed", {errIllegal, accValid}, 2'b10);
    issue(1'b0, C_WR, 2'd2, 13'h0011);
    chk("R8 wr closed", {errIllegal, accValid}, 2'b10);
    // R5 precharge all
    issue(1'b0, C_PRE, 2'd1, 13'h0400);
    expActive = '0;
    chk("R5 all close", bankActive, 0);
    chk("R5 rows kept", openRows, expRows());

    // R9 refresh with everything closed
    issue(1'b0, C_REF, 2'd3, 13'h1FFF);
    chk("R9 pulses", {accValid, mrsValid, errIllegal}, 0);
    chk("R9 state", bankActive, 0);

    // R8 MRS to bank address 2 and 3
    issue(1'b0, C_MRS, 2'd2, 13'h0002);
    chk("R8 mrs ba2", {errIllegal, mrsValid}, 2'b10);
    issue(1'b0, C_MRS, 2'd3, 13'h0002);
    chk("R8 mrs ba3", {errIllegal, mrsValid}, 2'b10);
    chk("R8 mrs ba mode kept", {mainMode, extMode}, {13'd1, 13'd0});

    // R7 extended register load does not change burst length
    issue(1'b0, C_MRS, 2'd1, 13'h0043);
    chk("R7 ext valid", {mrsValid, mrsTarget}, 2'b11);
    chk("R7 ext word", extMode, 13'h0043);
    issue(1'b0, C_ACT, 2'd1, 13'h0222);
    expActive[1] = 1'b1; expRow[1] = 13'h0222;
    issue(1'b0, C_RD, 2'd1, 13'h0400);
    apTiming(1, 2, "R6 ext no bl change");

    // R7/R6 sweep all burst codes on every bank
    for (int code = 0; code < 8; code++) begin
      issue(1'b0, C_MRS, 2'd0, 13'(13'h0030 | code));
      chk("R7 main valid", {mrsValid, mrsTarget}, 2'b10);
      chk("R7 main word", mainMode, 13'(13'h0030 | code));
      for (int b = 0; b < 4; b++) begin
        issue(1'b0, C_ACT, 2'(b), 13'(code * 100 + b));
        expActive[b] = 1'b1; expRow[b] = 13'(code * 100 + b);
        issue(1'b0, (b % 2) ? C_WR : C_RD, 2'(b), 13'(13'h0400 | (b * 50 + code)));
        chk("R6 autoPreReq", {accValid, autoPreReq}, 2'b11);
        chk("R6 accCol", accCol, 9'(b * 50 + code));
        apTiming(b, blOf(3'(code)), "R6 close timing");
      end
    end

    // R8 rejected MRS keeps burst length: set BL4, then try BL8 with a bank open
    issue(1'b0, C_MRS, 2'd0, 13'h0002);
    issue(1'b0, C_ACT, 2'd3, 13'h1234);
    expActive[3] = 1'b1;
    issue(1'b0, C_MRS, 2'd0, 13'h0003);
    chk("R8 mrs rejected", errIllegal, 1);
    issue(1'b0, C_WR, 2'd3, 13'h0400);
    apTiming(3, 4, "R8 bl kept at 4");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule